// File: doc/BRIEF.md
# Flash Command Sequencer

This block decodes host bus write cycles for a multi-bank NOR-style flash device. Each write carries an address and a 16-bit data word; the low byte of the data is taken as a command code. Three multi-cycle sequences are recognised: bank erase, two-word program and four-word program. For each one the sequencer latches the target bank, addresses and data, checks that the sequence is well formed, and then gives a one-cycle start pulse to an external program/erase engine. The engine reports completion with a done input. A sequence that is malformed is dropped and recorded in error bits of a device-wide status byte.

The block also keeps a read mode for every bank. The read path uses this mode to decide whether a read to that bank returns array data, status, the electronic signature or query data. Issuing an operation puts the affected bank into status mode. The bank keeps that mode after the operation ends, until the host writes another read command to it. While the engine is busy, only read commands are accepted. Every other write is dropped.

Top module: `flash_cmd_seq`

## Requirements
- R1: Writing 0x80 and then 0xD0 starts a bank erase. Both are low bytes of `wr_data`, and the bank is taken from the top address bits of the second write. On the cycle after the second write edge, `eng_start` is 1, `eng_op` is 0, `eng_bank` is the bank, and `eng_erase_mask` has a 1 for every block of that bank whose `blk_prot` bit is 0.
- R2: If the write after 0x80 is not 0xD0, no start is issued, status bits 5 and 4 are both set, and the sequencer returns to idle.
- R3: If every block of the addressed bank is protected, a confirmed erase issues no start and sets no status error bit.
- R4: Writing 0x30 and then two address/data pairs starts a two-word program on the second pair. `eng_op` is 1, `eng_addr` is the pair address with bit 0 cleared, and the word written at address bit 0 = k sits in `eng_data[16k+15:16k]`.
- R5: Writing 0x56 and then four address/data pairs starts a four-word program on the fourth pair. `eng_op` is 2, `eng_addr` has bits 1:0 cleared, and the word written at address bits 1:0 = k sits in `eng_data[16k+15:16k]`.
- R6: If a later pair's address differs from the first pair's address above bit 0 (two-word) or above bit 1 (four-word), the sequence aborts. Status bit 4 is set, bit 5 is left as it was, and no start is issued.
- R7: Read modes are encoded 0 array, 1 status, 2 signature, 3 query on `rd_mode` for the bank of `rd_addr`. Commands 0xFF, 0x70, 0x90 and 0x98 set the addressed bank to modes 0, 1, 2 and 3. An issued operation sets its bank to 1, and the bank stays at 1 after `eng_done` until a new read command is written.
- R8: While busy, only the four read commands take effect. Setup codes and the clear code 0x50 are ignored.
- R9: Status bit 7 is 0 from the start pulse until the cycle after `eng_done`, and 1 otherwise. Bits 6 and 3:0 are always 0.
- R10: Command 0x50, when not busy, clears status bits 5 and 4.
- R11: Synchronous reset (`rst_n` low at a clock edge) aborts any operation. Afterwards status reads 0x80, every bank is in array mode, and a new sequence is accepted.
- R12: `eng_start` is high for exactly one cycle per issued operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host bus write strobe |
| wr_addr | input | AW | Write address; top bits select bank and block |
| wr_data | input | DW | Write data; bits 7:0 are the command code |
| blk_prot | input | NBANK*BPB | Per-block protect flags, index bank*BPB+block |
| eng_done | input | 1 | Engine completion pulse |
| rd_addr | input | AW | Read address whose bank mode is reported |
| rd_mode | output | 2 | Read mode of the bank of rd_addr |
| status | output | 8 | Status byte: bit7 ready, bit5 erase error, bit4 program error |
| eng_start | output | 1 | One-cycle engine start |
| eng_op | output | 2 | Operation: 0 erase, 1 two-word, 2 four-word |
| eng_bank | output | log2(NBANK) | Bank of the erase |
| eng_addr | output | AW | Aligned base address of a program |
| eng_data | output | 4*DW | Program words by low address bits |
| eng_erase_mask | output | BPB | Unprotected blocks to erase |

## Verification
The assertions check, on every cycle, the properties that never depend on a scenario. The start is a single pulse. No start follows a busy cycle. The ready bit is low whenever a start is issued. An erase error never appears without the program error beside it. An erase start never carries an empty block mask. The bench scenarios are needed for the decoding itself: which code sequence leads to which operation, where the words land by address bit, the abort on broken adjacency, the mode sticking after completion, the commands ignored while busy, and recovery after a reset in mid-operation.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
   typedef enum logic [1:0] {OP_ERASE = 2'd0, OP_DW = 2'd1, OP_QW = 2'd2} op_e;
   typedef enum logic [1:0] {RM_ARRAY = 2'd0, RM_STATUS = 2'd1, RM_SIG = 2'd2, RM_CFI = 2'd3} rmode_e;
   typedef enum logic [1:0] {S_IDLE, S_ERS_CFM, S_PRG, S_BUSY} st_e;
endpackage

// File: rtl/fcs_status.sv
module fcs_status (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       busy,
   input  logic       set_ers,
   input  logic       set_prg,
   input  logic       clr_err,
   output logic [7:0] sr
);
   logic e_ers, e_prg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         e_ers <= 1'b0;
         e_prg <= 1'b0;
      end else if (clr_err) begin
         e_ers <= 1'b0;
         e_prg <= 1'b0;
      end else begin
         if (set_ers) e_ers <= 1'b1;
         if (set_prg) e_prg <= 1'b1;
      end
   end

   assign sr = {~busy, 1'b0, e_ers, e_prg, 4'b0000};

   // R2: an erase error is always reported together with the program error
   p_pair_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sr[5]) |-> sr[4]);
endmodule

// File: rtl/fcs_rdmode.sv
module fcs_rdmode #(
   parameter int NBANK = 4,
   localparam int BB = $clog2(NBANK)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [BB-1:0]         wbank,
   input  fcs_pkg::rmode_e       wval,
   input  logic [BB-1:0]         rbank,
   output fcs_pkg::rmode_e       rmode
);
   fcs_pkg::rmode_e mode_q [NBANK];

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      always_ff @(posedge clk) begin
         if (!rst_n)                          mode_q[b] <= fcs_pkg::RM_ARRAY;
         else if (we && wbank == BB'(b))      mode_q[b] <= wval;
      end
   end

   assign rmode = mode_q[rbank];
endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
   import fcs_pkg::*;
#(
   parameter int AW = 12,
   parameter int DW = 16,
   parameter int NBANK = 4,
   parameter int BPB = 4,
   parameter logic [7:0] C_ERASE = 8'h80,
   parameter logic [7:0] C_CONFIRM = 8'hD0,
   parameter logic [7:0] C_DW = 8'h30,
   parameter logic [7:0] C_QW = 8'h56,
   parameter logic [7:0] C_RD_ARRAY = 8'hFF,
   parameter logic [7:0] C_RD_STAT = 8'h70,
   parameter logic [7:0] C_RD_SIG = 8'h90,
   parameter logic [7:0] C_RD_CFI = 8'h98,
   parameter logic [7:0] C_CLR = 8'h50,
   localparam int BB = $clog2(NBANK)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [AW-1:0]        wr_addr,
   input  logic [DW-1:0]        wr_data,
   input  logic [NBANK*BPB-1:0] blk_prot,
   input  logic                 eng_done,
   output logic                 busy,
   output logic                 set_ers,
   output logic                 set_prg,
   output logic                 clr_err,
   output logic                 mode_we,
   output logic [BB-1:0]        mode_bank,
   output rmode_e               mode_val,
   output logic                 eng_start,
   output op_e                  eng_op,
   output logic [BB-1:0]        eng_bank,
   output logic [AW-1:0]        eng_addr,
   output logic [4*DW-1:0]      eng_data,
   output logic [BPB-1:0]       eng_mask
);
   st_e              st_q, st_d;
   op_e              op_q;
   logic [1:0]       cnt_q;
   logic [AW-1:0]    base_q;
   logic [DW-1:0]    data_q [4];
   logic [BB-1:0]    bank_q;
   logic [BPB-1:0]   mask_q;
   logic             start_q;

   logic [7:0]       cmd;
   logic [BB-1:0]    wbank;
   logic [BPB-1:0]   free_blk;
   logic [AW-1:0]    lowm;
   logic             hi_match, is_rd, go_ers, go_prg, lat_en, new_prg;
   op_e              new_op;
   logic [1:0]       slot, last;
   rmode_e           rd_val;

   assign cmd      = wr_data[7:0];
   assign wbank    = wr_addr[AW-1 -: BB];
   assign free_blk = ~blk_prot[wbank*BPB +: BPB];
   assign lowm     = {{(AW-2){1'b0}}, (op_q == OP_QW), 1'b1};
   assign hi_match = ((wr_addr ^ base_q) & ~lowm) == '0;
   assign slot     = (op_q == OP_QW) ? wr_addr[1:0] : {1'b0, wr_addr[0]};
   assign last     = (op_q == OP_QW) ? 2'd3 : 2'd1;

   always_comb begin
      is_rd  = 1'b1;
      rd_val = RM_ARRAY;
      case (cmd)
         C_RD_ARRAY: rd_val = RM_ARRAY;
         C_RD_STAT:  rd_val = RM_STATUS;
         C_RD_SIG:   rd_val = RM_SIG;
         C_RD_CFI:   rd_val = RM_CFI;
         default:    is_rd  = 1'b0;
      endcase
   end

   always_comb begin
      st_d = st_q;
      set_ers = 1'b0; set_prg = 1'b0; clr_err = 1'b0;
      mode_we = 1'b0; mode_bank = wbank; mode_val = rd_val;
      go_ers = 1'b0; go_prg = 1'b0; lat_en = 1'b0;
      new_prg = 1'b0; new_op = OP_DW;
      case (st_q)
         S_IDLE: if (wr_en) begin
            if (is_rd)                mode_we = 1'b1;
            else if (cmd == C_CLR)    clr_err = 1'b1;
            else if (cmd == C_ERASE)  st_d = S_ERS_CFM;
            else if (cmd == C_DW || cmd == C_QW) begin
               st_d = S_PRG;
               new_prg = 1'b1;
               new_op = (cmd == C_QW) ? OP_QW : OP_DW;
            end
         end
         S_ERS_CFM: if (wr_en) begin
            st_d = S_IDLE;
            if (cmd != C_CONFIRM) begin
               set_ers = 1'b1;
               set_prg = 1'b1;
            end else if (free_blk != '0) begin
               go_ers = 1'b1;
               st_d = S_BUSY;
               mode_we = 1'b1;
               mode_val = RM_STATUS;
            end
         end
         S_PRG: if (wr_en) begin
            if (cnt_q != 2'd0 && !hi_match) begin
               set_prg = 1'b1;
               st_d = S_IDLE;
            end else begin
               lat_en = 1'b1;
               if (cnt_q == last) begin
                  go_prg = 1'b1;
                  st_d = S_BUSY;
                  mode_we = 1'b1;
                  mode_val = RM_STATUS;
               end
            end
         end
         default: begin
            if (wr_en && is_rd) mode_we = 1'b1;
            if (eng_done)       st_d = S_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= S_IDLE;
         op_q <= OP_ERASE;
         cnt_q <= 2'd0;
         base_q <= '0;
         bank_q <= '0;
         mask_q <= '0;
         start_q <= 1'b0;
         for (int i = 0; i < 4; i++) data_q[i] <= '0;
      end else begin
         st_q <= st_d;
         start_q <= go_ers | go_prg;
         if (new_prg) begin
            op_q <= new_op;
            cnt_q <= 2'd0;
         end
         if (go_ers) begin
            op_q <= OP_ERASE;
            bank_q <= wbank;
            mask_q <= free_blk;
            base_q <= wr_addr;
         end
         if (lat_en) begin
            data_q[slot] <= wr_data;
            cnt_q <= cnt_q + 2'd1;
            if (cnt_q == 2'd0) base_q <= wr_addr;
         end
      end
   end

   assign busy      = (st_q == S_BUSY);
   assign eng_start = start_q;
   assign eng_op    = op_q;
   assign eng_bank  = bank_q;
   assign eng_addr  = base_q & ~lowm;
   assign eng_mask  = mask_q;
   for (genvar i = 0; i < 4; i++) begin : g_data
      assign eng_data[i*DW +: DW] = data_q[i];
   end

   // R12: the start strobe lasts one cycle
   p_one_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);
   // R8: a busy cycle is never followed by a new start
   p_quiet_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !eng_start);
   // R3: an erase is only launched with at least one block to erase
   p_mask_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_start && eng_op == OP_ERASE) |-> (eng_mask != '0));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
   parameter int AW = 12,
   parameter int DW = 16,
   parameter int NBANK = 4,
   parameter int BPB = 4,
   localparam int BB = $clog2(NBANK)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [AW-1:0]        wr_addr,
   input  logic [DW-1:0]        wr_data,
   input  logic [NBANK*BPB-1:0] blk_prot,
   input  logic                 eng_done,
   input  logic [AW-1:0]        rd_addr,
   output logic [1:0]           rd_mode,
   output logic [7:0]           status,
   output logic                 eng_start,
   output logic [1:0]           eng_op,
   output logic [BB-1:0]        eng_bank,
   output logic [AW-1:0]        eng_addr,
   output logic [4*DW-1:0]      eng_data,
   output logic [BPB-1:0]       eng_erase_mask
);
   if (NBANK < 2 || (1 << BB) != NBANK) begin : g_chk_bank
      $error("NBANK must be a power of two, at least 2");
   end
   if (BPB < 1 || AW < BB + $clog2(BPB) + 2) begin : g_chk_aw
      $error("AW too small for bank, block and word offset bits");
   end
   if (DW < 8) begin : g_chk_dw
      $error("DW must hold an 8-bit command code");
   end

   logic             busy, set_ers, set_prg, clr_err, mode_we;
   logic [BB-1:0]    mode_bank;
   fcs_pkg::rmode_e  mode_val, rmode;
   fcs_pkg::op_e     op;

   fcs_seq #(.AW(AW), .DW(DW), .NBANK(NBANK), .BPB(BPB)) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .blk_prot(blk_prot), .eng_done(eng_done),
      .busy(busy), .set_ers(set_ers), .set_prg(set_prg), .clr_err(clr_err),
      .mode_we(mode_we), .mode_bank(mode_bank), .mode_val(mode_val),
      .eng_start(eng_start), .eng_op(op), .eng_bank(eng_bank),
      .eng_addr(eng_addr), .eng_data(eng_data), .eng_mask(eng_erase_mask)
   );

   fcs_status u_status (
      .clk(clk), .rst_n(rst_n), .busy(busy), .set_ers(set_ers),
      .set_prg(set_prg), .clr_err(clr_err), .sr(status)
   );

   fcs_rdmode #(.NBANK(NBANK)) u_rdmode (
      .clk(clk), .rst_n(rst_n), .we(mode_we), .wbank(mode_bank),
      .wval(mode_val), .rbank(rd_addr[AW-1 -: BB]), .rmode(rmode)
   );

   assign eng_op  = op;
   assign rd_mode = rmode;

   // R9: ready is low whenever the engine is being started
   p_ready_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> !status[7]);
   // R7: a bank that has just been given an erase reads status
   p_ers_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_start && op == fcs_pkg::OP_ERASE && rd_addr[AW-1 -: BB] == eng_bank)
         |-> rd_mode == 2'd1);
endmodule

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] blk_prot = 16'h0F20;
   logic        eng_done = 1'b0;
   logic [11:0] rd_addr = '0;
   logic [1:0]  rd_mode;
   logic [7:0]  status;
   logic        eng_start;
   logic [1:0]  eng_op;
   logic [1:0]  eng_bank;
   logic [11:0] eng_addr;
   logic [63:0] eng_data;
   logic [3:0]  eng_erase_mask;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   flash_cmd_seq u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .blk_prot(blk_prot), .eng_done(eng_done),
      .rd_addr(rd_addr), .rd_mode(rd_mode), .status(status),
      .eng_start(eng_start), .eng_op(eng_op), .eng_bank(eng_bank),
      .eng_addr(eng_addr), .eng_data(eng_data), .eng_erase_mask(eng_erase_mask)
   );

   // entry: we, addr, data, done, expected start, expected status
   localparam int NV = 20;
   localparam logic [38:0] VEC [NV] = '{
      {1'b0, 12'h000, 16'h0000, 1'b0, 1'b0, 8'h80},   // idle
      {1'b1, 12'h400, 16'h0080, 1'b0, 1'b0, 8'h80},   // R1 setup
      {1'b1, 12'h400, 16'h00D0, 1'b0, 1'b1, 8'h00},   // R1 confirm
      {1'b1, 12'h000, 16'h0080, 1'b0, 1'b0, 8'h00},   // R8 ignored
      {1'b0, 12'h000, 16'h0000, 1'b1, 1'b0, 8'h80},   // R9 done
      {1'b1, 12'h000, 16'h0080, 1'b0, 1'b0, 8'h80},   // R2 setup
      {1'b1, 12'h000, 16'h0012, 1'b0, 1'b0, 8'hB0},   // R2 bad confirm
      {1'b1, 12'h100, 16'h0030, 1'b0, 1'b0, 8'hB0},   // R4 setup
      {1'b1, 12'h105, 16'hAAAA, 1'b0, 1'b0, 8'hB0},   // R4 first pair
      {1'b1, 12'h104, 16'h5555, 1'b0, 1'b1, 8'h30},   // R4 second pair
      {1'b1, 12'h000, 16'h0050, 1'b0, 1'b0, 8'h30},   // R8 clear ignored
      {1'b0, 12'h000, 16'h0000, 1'b1, 1'b0, 8'hB0},   // R9 done
      {1'b1, 12'h000, 16'h0050, 1'b0, 1'b0, 8'h80},   // R10 clear
      {1'b1, 12'h800, 16'h0080, 1'b0, 1'b0, 8'h80},   // R3 setup
      {1'b1, 12'h800, 16'h00D0, 1'b0, 1'b0, 8'h80},   // R3 all protected
      {1'b1, 12'h200, 16'h0056, 1'b0, 1'b0, 8'h80},   // R6 setup
      {1'b1, 12'h203, 16'h1111, 1'b0, 1'b0, 8'h80},   // R6 pair
      {1'b1, 12'h200, 16'h2222, 1'b0, 1'b0, 8'h80},   // R6 pair
      {1'b1, 12'h206, 16'h3333, 1'b0, 1'b0, 8'h90},   // R6 broken adjacency
      {1'b1, 12'h000, 16'h0050, 1'b0, 1'b0, 8'h80}    // R10 clear
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input logic we, input logic [11:0] a, input logic [15:0] d, input logic dn);
      wr_en = we; wr_addr = a; wr_data = d; eng_done = dn;
      @(negedge clk);
      wr_en = 1'b0; eng_done = 1'b0;
   endtask

   task automatic finish_run();
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11: reset state
      chk("R11 reset status", 64'(status), 64'h80);
      chk("R12 reset start", 64'(eng_start), 64'h0);
      chk("R11 reset mode", 64'(rd_mode), 64'h0);

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][38], VEC[i][37:26], VEC[i][25:10], VEC[i][9]);
         chk($sformatf("vec %0d R1-table start", i), 64'(eng_start), 64'(VEC[i][8]));
         chk($sformatf("vec %0d R9 status", i), 64'(status), 64'(VEC[i][7:0]));
      end

      // R1 erase mask and bank, R7 sticky status mode
      rd_addr = 12'h400;
      step(1'b1, 12'h400, 16'h0080, 1'b0);
      step(1'b1, 12'h400, 16'h00D0, 1'b0);
      chk("R1 start", 64'(eng_start), 64'h1);
      chk("R1 op", 64'(eng_op), 64'h0);
      chk("R1 bank", 64'(eng_bank), 64'h1);
      chk("R1 mask", 64'(eng_erase_mask), 64'hD);
      chk("R7 status mode", 64'(rd_mode), 64'h1);
      step(1'b0, 12'h000, 16'h0000, 1'b1);
      chk("R9 ready after done", 64'(status), 64'h80);
      chk("R7 mode sticks", 64'(rd_mode), 64'h1);
      step(1'b1, 12'h400, 16'h00FF, 1'b0);
      chk("R7 read array", 64'(rd_mode), 64'h0);

      // R4 two-word data placement
      step(1'b1, 12'h0F0, 16'h0030, 1'b0);
      step(1'b1, 12'h0F1, 16'hBEEF, 1'b0);
      step(1'b1, 12'h0F0, 16'hCAFE, 1'b0);
      chk("R4 start", 64'(eng_start), 64'h1);
      chk("R4 op", 64'(eng_op), 64'h1);
      chk("R4 addr", 64'(eng_addr), 64'h0F0);
      chk("R4 data", 64'(eng_data[31:0]), 64'hBEEFCAFE);
      step(1'b0, 12'h000, 16'h0000, 1'b1);

      // R5 four-word data placement, R12 single pulse
      step(1'b1, 12'h300, 16'h0056, 1'b0);
      step(1'b1, 12'h303, 16'hDDDD, 1'b0);
      step(1'b1, 12'h301, 16'hBBBB, 1'b0);
      step(1'b1, 12'h300, 16'hAAAA, 1'b0);
      chk("R5 no early start", 64'(eng_start), 64'h0);
      step(1'b1, 12'h302, 16'hCCCC, 1'b0);
      chk("R5 start", 64'(eng_start), 64'h1);
      chk("R5 op", 64'(eng_op), 64'h2);
      chk("R5 addr", 64'(eng_addr), 64'h300);
      chk("R5 data", eng_data, 64'hDDDDCCCCBBBBAAAA);
      step(1'b0, 12'h000, 16'h0000, 1'b0);
      chk("R12 pulse ends", 64'(eng_start), 64'h0);
      chk("R9 still busy", 64'(status), 64'h00);
      step(1'b0, 12'h000, 16'h0000, 1'b1);

      // R7 signature and query modes, other bank untouched
      rd_addr = 12'h000;
      step(1'b1, 12'h000, 16'h0090, 1'b0);
      chk("R7 signature", 64'(rd_mode), 64'h2);
      step(1'b1, 12'h000, 16'h0098, 1'b0);
      chk("R7 query", 64'(rd_mode), 64'h3);
      rd_addr = 12'h400;
      #1 chk("R7 other bank", 64'(rd_mode), 64'h0);

      // R11 reset mid-erase
      rd_addr = 12'hC00;
      step(1'b1, 12'hC00, 16'h0080, 1'b0);
      step(1'b1, 12'hC00, 16'h00D0, 1'b0);
      chk("R1 bank3 mask", 64'(eng_erase_mask), 64'hF);
      chk("R9 busy", 64'(status), 64'h00);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R11 status", 64'(status), 64'h80);
      chk("R11 mode bank3", 64'(rd_mode), 64'h0);
      rd_addr = 12'h000;
      #1 chk("R11 mode bank0", 64'(rd_mode), 64'h0);
      @(negedge clk);
      step(1'b1, 12'hC00, 16'h0080, 1'b0);
      step(1'b1, 12'hC00, 16'h00D0, 1'b0);
      chk("R11 restart", 64'(eng_start), 64'h1);
      step(1'b0, 12'h000, 16'h0000, 1'b1);

      finish_run();
   end
endmodule